// File: doc/BRIEF.md
# Intra 4x4 Angular Edge Predictor

This block forms the 4x4 predicted block of 8-bit samples for the six angular intra modes of a block-based video coder: down-left diagonal, down-right diagonal, vertical-right, horizontal-down, vertical-left and horizontal-up. A request carries the neighbouring reconstructed samples: eight samples above the block (the last four lie above and to the right), the corner sample above and to the left, and four samples in the left column. It also carries a mode code and a flag that says whether the four above-right samples may be used. The block lines the neighbours up as a single padded edge vector. It runs a rounding 3-tap and a rounding 2-tap smoother at every edge position, then places the smoothed values into the 4x4 output with an index pattern chosen by the mode.

A valid/ready pair carries requests in and results out. A controller with three named states sequences the work. In `ST_IDLE` the block is ready and waits for a request. On acceptance it goes to `ST_SCAT`, and the filter outputs are registered on that same edge. On the next edge it always goes to `ST_SHOW`, and the scattered pixels are registered on that edge. `ST_SHOW` presents the result and holds it until the consumer takes it. It then returns to `ST_IDLE`. Each request takes exactly two clock edges from acceptance to a valid result.

Top module: `ipred4_edge_pred`

## Requirements
- R1: Mode code 3 (down-left diagonal): pixel (x,y) is the 3-tap value centred on above sample x+y+1. The above row is extended past its eighth sample by repeating that sample, so pixel (3,3) is (U6 + 3*U7 + 2) >> 2.
- R2: Mode code 4 (down-right diagonal): with the edge ordered L3, L2, L1, L0, corner, U0..U3, pixel (x,y) is the 3-tap value centred on the corner shifted by x−y positions along that edge. Each row is the row above moved right by one.
- R3: Mode code 5 (vertical-right): the top rows alternate 2-tap averages of corner/U0..U3 pairs with 3-tap values. Pixel (0,1) is centred on the corner. Pixels (0,2) and (0,3) are 3-tap values centred on L0 and L1.
- R4: Mode code 6 (horizontal-down): the left column and corner produce interleaved 2-tap and 3-tap values, and each row starts two interleaved positions earlier than the row below. Pixels (2,0) and (3,0) are 3-tap values centred on U0 and U1.
- R5: Mode code 7 (vertical-left): even rows hold 2-tap averages of adjacent above samples and odd rows hold 3-tap values. The window moves one above sample for every two rows.
- R6: Mode code 8 (horizontal-up): the left column produces interleaved 2-tap and 3-tap values, padded below L3 with L3. Pixel (1,2) is (L2 + 3*L3 + 2) >> 2. Every pixel with x + 2y > 5 equals L3.
- R7: When the above-right flag is 0, U4..U7 are replaced by U3 before filtering. This changes modes 3 and 7, and in the other modes the flag has no effect on the result.
- R8: The 3-tap value is (a + 2b + c + 2) >> 2 and the 2-tap value is (a + b + 1) >> 1. Both are computed without overflow, so all-255 neighbours give all-255 pixels and all-zero neighbours give all-zero pixels.
- R9: A request is accepted on an edge where in_valid and in_ready are both high. in_ready is low from the following cycle until the result has been taken. out_valid rises on the second edge after acceptance.
- R10: While out_valid is high and out_ready is low, out_valid stays high and out_pix does not change.
- R11: A mode code outside 3..8 is accepted and produces an all-zero result.
- R12: During and right after reset, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can accept a request |
| in_mode | input | MODE_W (4) | Prediction mode code |
| in_ur_ok | input | 1 | Above-right samples U4..U7 usable |
| in_above | input | 8*PIX_W (64) | Above samples, U k at bits [8k+7:8k] |
| in_corner | input | PIX_W (8) | Above-left corner sample |
| in_left | input | 4*PIX_W (32) | Left samples, L k at bits [8k+7:8k] |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_pix | output | 16*PIX_W (128) | Pixel (x,y) at bits [8(4y+x)+7:8(4y+x)] |

## Verification
The hardest situation to reach from the ports is one where the above-right substitution matters. If U4..U7 happen to equal U3, or a mode never reads them, a faulty substitution produces the right pixels. The stimulus therefore draws U4..U7 independently of U3 and sweeps every mode code under both flag values, so the four modes that must ignore the flag are also shown to ignore it. A second hard case is the pair of edge ends: the repeat past U7 and the fill below L3 only show with distinct end samples and saturated patterns, which the sweep includes. A stalled consumer is held off for several cycles on some requests to expose any drift of the held result.

// File: rtl/ipred4_pkg.sv
package ipred4_pkg;
    // Edge vector layout (entry index): 0 pad(L3), 1 L3, 2 L2, 3 L1, 4 L0,
    // 5 corner, 6..13 U0..U7, 14 pad(U7)
    localparam int EDGE_N   = 15;
    localparam int E_CORNER = 5;
    localparam int E_ABOVE0 = 6;
    localparam int N_ABOVE  = 8;
    localparam int N_LEFT   = 4;
    localparam int BLK      = 4;

    localparam int MD_DDL = 3;
    localparam int MD_DDR = 4;
    localparam int MD_VR  = 5;
    localparam int MD_HD  = 6;
    localparam int MD_VL  = 7;
    localparam int MD_HU  = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAT = 2'd1,
        ST_SHOW = 2'd2
    } ctl_st_e;
endpackage

// File: rtl/ipred4_taps.sv
module ipred4_taps
    import ipred4_pkg::*;
#(
    parameter int PIX_W = 8
) (
    input  logic [EDGE_N*PIX_W-1:0] edge_v,
    output logic [EDGE_N*PIX_W-1:0] tap3,
    output logic [EDGE_N*PIX_W-1:0] tap2
);
    localparam int ACC_W = PIX_W + 2;

    for (genvar i = 0; i < EDGE_N; i++) begin : g_pos
        if (i >= 1 && i <= EDGE_N - 2) begin : g_t3
            logic [ACC_W-1:0] s3;
            assign s3 = ACC_W'(edge_v[(i-1)*PIX_W +: PIX_W])
                      + (ACC_W'(edge_v[i*PIX_W +: PIX_W]) << 1)
                      + ACC_W'(edge_v[(i+1)*PIX_W +: PIX_W])
                      + ACC_W'(2);
            assign tap3[i*PIX_W +: PIX_W] = s3[ACC_W-1:2];
        end else begin : g_t3_none
            assign tap3[i*PIX_W +: PIX_W] = '0;
        end

        if (i <= EDGE_N - 2) begin : g_t2
            logic [PIX_W:0] s2;
            assign s2 = (PIX_W+1)'(edge_v[i*PIX_W +: PIX_W])
                      + (PIX_W+1)'(edge_v[(i+1)*PIX_W +: PIX_W])
                      + (PIX_W+1)'(1);
            assign tap2[i*PIX_W +: PIX_W] = s2[PIX_W:1];
        end else begin : g_t2_none
            assign tap2[i*PIX_W +: PIX_W] = '0;
        end
    end
endmodule

// File: rtl/ipred4_scatter.sv
module ipred4_scatter
    import ipred4_pkg::*;
#(
    parameter int PIX_W  = 8,
    parameter int MODE_W = 4
) (
    input  logic [MODE_W-1:0]           mode,
    input  logic [EDGE_N*PIX_W-1:0]     tap3,
    input  logic [EDGE_N*PIX_W-1:0]     tap2,
    output logic [BLK*BLK*PIX_W-1:0]    pix
);
    int   idx;
    int   z;
    logic use3;
    logic kill;

    always_comb begin
        pix  = '0;
        idx  = 0;
        z    = 0;
        use3 = 1'b0;
        kill = 1'b0;
        for (int y = 0; y < BLK; y++) begin
            for (int x = 0; x < BLK; x++) begin
                use3 = 1'b1;
                kill = 1'b0;
                idx  = 0;
                z    = 0;
                case (int'(mode))
                    MD_DDL: idx = 7 + x + y;
                    MD_DDR: idx = 5 + x - y;
                    MD_VR: begin
                        z = 2 * x - y;
                        if (z >= 0 && z % 2 == 0) begin
                            use3 = 1'b0;
                            idx  = 5 + x - (y >> 1);
                        end else if (z > 0) begin
                            idx = 5 + x - (y >> 1);
                        end else if (z == -1) begin
                            idx = E_CORNER;
                        end else begin
                            idx = 6 - y;
                        end
                    end
                    MD_HD: begin
                        z = 2 * y - x;
                        if (z >= 0 && z % 2 == 0) begin
                            use3 = 1'b0;
                            idx  = 4 - y + (x >> 1);
                        end else if (z > 0) begin
                            idx = 5 - y + (x >> 1);
                        end else if (z == -1) begin
                            idx = E_CORNER;
                        end else begin
                            idx = 4 + x;
                        end
                    end
                    MD_VL: begin
                        if (y % 2 == 0) begin
                            use3 = 1'b0;
                            idx  = 6 + x + (y >> 1);
                        end else begin
                            idx = 7 + x + (y >> 1);
                        end
                    end
                    MD_HU: begin
                        z = x + 2 * y;
                        if (z > 5) begin
                            use3 = 1'b0;  // tap2 at 0 averages L3 with itself
                            idx  = 0;
                        end else if (z == 5) begin
                            idx = 1;
                        end else if (z % 2 == 0) begin
                            use3 = 1'b0;
                            idx  = 3 - y - (x >> 1);
                        end else begin
                            idx = 3 - y - (x >> 1);
                        end
                    end
                    default: kill = 1'b1;
                endcase
                if (!kill) begin
                    pix[(BLK*y+x)*PIX_W +: PIX_W] =
                        use3 ? tap3[idx*PIX_W +: PIX_W] : tap2[idx*PIX_W +: PIX_W];
                end
            end
        end
    end
endmodule

// File: rtl/ipred4_edge_pred.sv
module ipred4_edge_pred
    import ipred4_pkg::*;
#(
    parameter int PIX_W  = 8,
    parameter int MODE_W = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    output logic                        in_ready,
    input  logic [MODE_W-1:0]           in_mode,
    input  logic                        in_ur_ok,
    input  logic [N_ABOVE*PIX_W-1:0]    in_above,
    input  logic [PIX_W-1:0]            in_corner,
    input  logic [N_LEFT*PIX_W-1:0]     in_left,
    output logic                        out_valid,
    input  logic                        out_ready,
    output logic [BLK*BLK*PIX_W-1:0]    out_pix
);
    localparam int EV_W  = EDGE_N * PIX_W;
    localparam int OUT_W = BLK * BLK * PIX_W;

    ctl_st_e state_q, state_d;

    logic [EV_W-1:0]   edge_v;
    logic [EV_W-1:0]   tap3_d, tap2_d, tap3_q, tap2_q;
    logic [MODE_W-1:0] mode_q;
    logic [OUT_W-1:0]  pix_d;
    logic              take;

    // Edge assembly: left column reversed below the corner, above row after it
    assign edge_v[0 +: PIX_W]             = in_left[(N_LEFT-1)*PIX_W +: PIX_W];
    assign edge_v[E_CORNER*PIX_W +: PIX_W] = in_corner;
    for (genvar j = 0; j < N_LEFT; j++) begin : g_left
        assign edge_v[(E_CORNER-1-j)*PIX_W +: PIX_W] = in_left[j*PIX_W +: PIX_W];
    end
    for (genvar k = 0; k < N_ABOVE; k++) begin : g_above
        if (k < 4) begin : g_near
            assign edge_v[(E_ABOVE0+k)*PIX_W +: PIX_W] = in_above[k*PIX_W +: PIX_W];
        end else begin : g_far
            assign edge_v[(E_ABOVE0+k)*PIX_W +: PIX_W] =
                in_ur_ok ? in_above[k*PIX_W +: PIX_W] : in_above[3*PIX_W +: PIX_W];
        end
    end
    assign edge_v[(EDGE_N-1)*PIX_W +: PIX_W] = edge_v[(EDGE_N-2)*PIX_W +: PIX_W];

    ipred4_taps #(.PIX_W(PIX_W)) u_taps (
        .edge_v (edge_v),
        .tap3   (tap3_d),
        .tap2   (tap2_d)
    );

    ipred4_scatter #(.PIX_W(PIX_W), .MODE_W(MODE_W)) u_scatter (
        .mode (mode_q),
        .tap3 (tap3_q),
        .tap2 (tap2_q),
        .pix  (pix_d)
    );

    assign take = in_valid && in_ready;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (take) state_d = ST_SCAT;
            ST_SCAT: state_d = ST_SHOW;
            ST_SHOW: if (out_ready) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: in_ready  = 1'b1;
            ST_SCAT: ;
            ST_SHOW: out_valid = 1'b1;
            default: ;
        endcase
    end

    // Datapath registers: filter stage on accept, scatter stage in ST_SCAT
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tap3_q  <= '0;
            tap2_q  <= '0;
            mode_q  <= '0;
            out_pix <= '0;
        end else begin
            if (take) begin
                tap3_q <= tap3_d;
                tap2_q <= tap2_d;
                mode_q <= in_mode;
            end
            if (state_q == ST_SCAT) out_pix <= pix_d;
        end
    end
endmodule

// File: rtl/ipred4_edge_pred_chk.sv
module ipred4_edge_pred_chk #(
    parameter int PIX_W  = 8,
    parameter int MODE_W = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   in_valid,
    input logic                   in_ready,
    input logic                   out_valid,
    input logic                   out_ready,
    input logic [16*PIX_W-1:0]    out_pix,
    input logic [MODE_W-1:0]      mode_q
);
    p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> !in_ready);

    p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> ##1 out_valid);

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_pix));

    p_unsup_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (mode_q < MODE_W'(3) || mode_q > MODE_W'(8)) |-> out_pix == '0);

    p_hu_tail_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && mode_q == MODE_W'(8) |->
            out_pix[15*PIX_W +: PIX_W] == out_pix[14*PIX_W +: PIX_W] &&
            out_pix[15*PIX_W +: PIX_W] == out_pix[11*PIX_W +: PIX_W]);
endmodule

bind ipred4_edge_pred ipred4_edge_pred_chk #(.PIX_W(PIX_W), .MODE_W(MODE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_pix   (out_pix),
    .mode_q    (mode_q)
);

// File: tb/test_ipred4_edge_pred.sv
`timescale 1ns/1ps
module test_ipred4_edge_pred;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid, in_ready, in_ur_ok, out_valid, out_ready;
    logic [3:0]   in_mode;
    logic [63:0]  in_above;
    logic [7:0]   in_corner;
    logic [31:0]  in_left;
    logic [127:0] out_pix;

    int n_run = 0;
    int n_fail = 0;

    logic [7:0] s_up [8];
    logic [7:0] s_lf [4];
    logic [7:0] s_ul;
    bit         s_ur;
    logic [31:0] seed = 32'h1234_5678;

    always #4 clk = ~clk;  // 125 MHz

    ipred4_edge_pred i_ipred4_edge_pred (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_mode(in_mode), .in_ur_ok(in_ur_ok), .in_above(in_above),
        .in_corner(in_corner), .in_left(in_left), .out_valid(out_valid),
        .out_ready(out_ready), .out_pix(out_pix)
    );

    task automatic chk(input string req, input logic [127:0] got, input logic [127:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h exp %h", req, got, exp);
        end
    endtask

    function automatic int up(input int k);
        if (k < 0) return int'(s_ul);
        if (k > 7) k = 7;
        if (k >= 4 && !s_ur) return int'(s_up[3]);
        return int'(s_up[k]);
    endfunction

    function automatic int lf(input int k);
        if (k < 0) return int'(s_ul);
        return int'(s_lf[k]);
    endfunction

    function automatic int t3(input int a, input int b, input int c);
        return (a + 2 * b + c + 2) >> 2;
    endfunction

    function automatic int t2(input int a, input int b);
        return (a + b + 1) >> 1;
    endfunction

    function automatic int ref_px(input int md, input int x, input int y);
        int z;
        case (md)
            3: if (x == 3 && y == 3) return t3(up(6), up(7), up(7));
               else return t3(up(x+y), up(x+y+1), up(x+y+2));
            4: if (x > y) return t3(up(x-y-2), up(x-y-1), up(x-y));
               else if (x < y) return t3(lf(y-x-2), lf(y-x-1), lf(y-x));
               else return t3(up(0), s_ul, lf(0));
            5: begin
                z = 2 * x - y;
                if (z >= 0 && z % 2 == 0) return t2(up(x-(y>>1)-1), up(x-(y>>1)));
                if (z > 0) return t3(up(x-(y>>1)-2), up(x-(y>>1)-1), up(x-(y>>1)));
                if (z == -1) return t3(lf(0), s_ul, up(0));
                return t3(lf(y-1), lf(y-2), lf(y-3));
            end
            6: begin
                z = 2 * y - x;
                if (z >= 0 && z % 2 == 0) return t2(lf(y-(x>>1)-1), lf(y-(x>>1)));
                if (z > 0) return t3(lf(y-(x>>1)-2), lf(y-(x>>1)-1), lf(y-(x>>1)));
                if (z == -1) return t3(lf(0), s_ul, up(0));
                return t3(up(x-1), up(x-2), up(x-3));
            end
            7: if (y % 2 == 0) return t2(up(x+(y>>1)), up(x+(y>>1)+1));
               else return t3(up(x+(y>>1)), up(x+(y>>1)+1), up(x+(y>>1)+2));
            8: begin
                z = x + 2 * y;
                if (z > 5) return lf(3);
                if (z == 5) return t3(lf(2), lf(3), lf(3));
                if (z % 2 == 0) return t2(lf(y+(x>>1)), lf(y+(x>>1)+1));
                return t3(lf(y+(x>>1)), lf(y+(x>>1)+1), lf(y+(x>>1)+2));
            end
            default: return 0;
        endcase
    endfunction

    function automatic logic [127:0] ref_blk(input int md);
        logic [127:0] r = '0;
        for (int y = 0; y < 4; y++)
            for (int x = 0; x < 4; x++)
                r[(4*y+x)*8 +: 8] = 8'(ref_px(md, x, y));
        return r;
    endfunction

    function automatic logic [7:0] rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed[23:16];
    endfunction

    task automatic fill(input int pat);
        for (int k = 0; k < 8; k++) begin
            case (pat)
                0: s_up[k] = 8'h00;
                1: s_up[k] = 8'hFF;
                2: s_up[k] = 8'(20 * k + 7);
                3: s_up[k] = (k % 2 == 0) ? 8'h00 : 8'hFF;
                default: s_up[k] = rnd();
            endcase
        end
        for (int k = 0; k < 4; k++) begin
            case (pat)
                0: s_lf[k] = 8'h00;
                1: s_lf[k] = 8'hFF;
                2: s_lf[k] = 8'(200 - 30 * k);
                3: s_lf[k] = (k % 2 == 0) ? 8'hFF : 8'h00;
                default: s_lf[k] = rnd();
            endcase
        end
        s_ul = (pat == 0) ? 8'h00 : (pat == 1) ? 8'hFF : (pat == 2) ? 8'd99 : rnd();
    endtask

    function automatic string tag_of(input int md, input int pat);
        string t;
        case (md)
            3: t = s_ur ? "R1" : "R1/R7";
            4: t = s_ur ? "R2" : "R2/R7";
            5: t = s_ur ? "R3" : "R3/R7";
            6: t = s_ur ? "R4" : "R4/R7";
            7: t = s_ur ? "R5" : "R5/R7";
            8: t = s_ur ? "R6" : "R6/R7";
            default: t = "R11";
        endcase
        if (pat < 2) t = {t, "/R8"};
        return t;
    endfunction

    task automatic run(input int md, input int pat, input int hold);
        logic [127:0] first;
        @(negedge clk);
        in_valid = 1'b1;
        in_mode  = 4'(md);
        in_ur_ok = s_ur;
        for (int k = 0; k < 8; k++) in_above[k*8 +: 8] = s_up[k];
        for (int k = 0; k < 4; k++) in_left[k*8 +: 8] = s_lf[k];
        in_corner = s_ul;
        chk("R9 ready before accept", {127'd0, in_ready}, 128'd1);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        in_above = '1;  // inputs change after accept; result must not follow
        in_left  = '1;
        chk("R9 busy after accept", {126'd0, out_valid, in_ready}, 128'd0);
        @(posedge clk);
        @(negedge clk);
        chk("R9 valid two edges after accept", {127'd0, out_valid}, 128'd1);
        chk(tag_of(md, pat), out_pix, ref_blk(md));
        first = out_pix;
        for (int h = 0; h < hold; h++) begin
            @(posedge clk);
            @(negedge clk);
            chk("R10 held under stall", {out_valid, out_pix[126:0]}, {1'b1, first[126:0]});
        end
        out_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        out_ready = 1'b0;
        chk("R9 idle after take", {126'd0, out_valid, in_ready}, 128'd1);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0; in_mode = '0;
        in_ur_ok = 1'b0; in_above = '0; in_left = '0; in_corner = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R12 reset state", {126'd0, out_valid, in_ready}, 128'd1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 after reset", {126'd0, out_valid, in_ready}, 128'd1);
        for (int pat = 0; pat < 8; pat++) begin
            for (int ur = 0; ur < 2; ur++) begin
                for (int md = 0; md < 10; md++) begin
                    fill(pat);
                    s_ur = (ur == 1);
                    run(md, pat, (pat == 2 || pat == 5) && md >= 4 ? 3 : 0);
                end
            end
        end
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule